// File: doc/BRIEF.md
# Multi-Mode Quadrature Pulse Counter

This block is a signed event counter that is driven by two pulse inputs, `pin_a` and `pin_b`. Both inputs pass through a synchroniser, and their edges are then decoded into up and down steps. The decoding follows one of four input schemes:

- single-phase counting, with direction taken from the level of `pin_b`;
- single-phase counting, with direction taken from a software bit;
- separate up and down pulse lines;
- two-phase quadrature, with x1, x2 or x4 resolution.

A second setting chooses what happens at the range limits. In linear mode the count saturates and raises a sticky carry or borrow flag. In ring mode the count wraps between a programmable lower and upper bound.

The limit behaviour is a small state machine with three states: `CNT_RUN`, `CNT_CARRY` and `CNT_BORROW`. It has these transitions:

- `CNT_RUN` goes to `CNT_CARRY` on an up step at the maximum in linear mode.
- `CNT_RUN` goes to `CNT_BORROW` on a down step at the minimum in linear mode.
- `CNT_CARRY` or `CNT_BORROW` goes back to `CNT_RUN` when `flag_clr` is high.

While the machine is in either flag state, steps are discarded. A preset value can be loaded at any time, either from a pin or from a software strobe.

Top module: `quad_pulse_counter`

## Requirements
- R1: During and after reset the count is 0 and both flags are low.
- R2: In quadrature mode (`cfg_in_mode`=3), the count direction follows the leading phase. The sequence {a,b} 00→10→11→01→00 counts up and the reverse counts down. `cfg_mult`=0 counts rising edges of A only, 1 counts both edges of A, and 2 or 3 counts every edge of A and B.
- R3: In quadrature mode, a cycle in which both synchronised phases change is ignored.
- R4: With `cfg_in_mode`=0, each rising edge of A counts down if B is high and up if B is low.
- R5: With `cfg_in_mode`=1, each rising edge of A counts down if `cfg_sw_dir`=1 and up if it is 0.
- R6: With `cfg_in_mode`=2, a rising edge of A increments and a rising edge of B decrements. Rising edges of A and B in the same cycle cancel.
- R7: While `cnt_en` is low, no step changes the count.
- R8: A high `preset_pin` or `preset_sw` loads `preset_val` on the next clock, whatever the state of `cnt_en`.
- R9: In linear mode (`cfg_ring`=0), an up step at 2147483647 sets `carry_flag` and leaves the count there. The flag and the hold persist until `flag_clr` is asserted.
- R10: In linear mode, a down step at -2147483648 sets `borrow_flag` and holds the count. The flag and the hold clear only with `flag_clr`.
- R11: In ring mode, an up step at `ring_hi` loads `ring_lo`, and a down step at `ring_lo` loads `ring_hi`. A count inside the bounds never leaves them.
- R12: A pin change is reflected in the count on the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | Phase A pulse input (asynchronous) |
| pin_b | input | 1 | Phase B pulse input (asynchronous) |
| cfg_in_mode | input | 2 | 0 single/B dir, 1 single/soft dir, 2 up-down lines, 3 quadrature |
| cfg_mult | input | 2 | Quadrature resolution: 0 x1, 1 x2, 2/3 x4 |
| cfg_sw_dir | input | 1 | Software direction, 1 = down |
| cfg_ring | input | 1 | 1 = ring wrap, 0 = linear saturate |
| cnt_en | input | 1 | Count enable |
| ring_lo | input | CW | Ring lower bound (signed) |
| ring_hi | input | CW | Ring upper bound (signed) |
| preset_val | input | CW | Value loaded on preset |
| preset_pin | input | 1 | Preset request from a pin |
| preset_sw | input | 1 | Preset request from software |
| flag_clr | input | 1 | Clears carry/borrow and resumes counting |
| count | output | CW | Signed count value |
| carry_flag | output | 1 | Sticky overflow flag (linear) |
| borrow_flag | output | 1 | Sticky underflow flag (linear) |

## Verification
The checker watches four properties on every cycle:

- the count holds while counting is disabled or a flag is set;
- each flag stays set until `flag_clr` is asserted, and the two flags are never both set;
- a preset lands on the following clock;
- a ring-mode count never leaves its bounds.

Some behaviour can only be shown by the bench scenarios. These are the direction decoding for every input scheme and resolution, the rejection of a simultaneous change on both phases, the exact three-edge latency, and the wrap and saturate values at the limits, because each of them depends on a particular sequence of pins.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;

    typedef enum logic [1:0] {
        IN_PULSE_BDIR  = 2'd0,
        IN_PULSE_SWDIR = 2'd1,
        IN_UPDOWN      = 2'd2,
        IN_QUAD        = 2'd3
    } in_mode_e;

    typedef enum logic [1:0] {
        MUL_X1  = 2'd0,
        MUL_X2  = 2'd1,
        MUL_X4  = 2'd2,
        MUL_X4B = 2'd3
    } mult_e;

    typedef enum logic [1:0] {
        CNT_RUN    = 2'd0,
        CNT_CARRY  = 2'd1,
        CNT_BORROW = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/qpc_sync.sv
`timescale 1ns/1ps
module qpc_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] chg
);

    logic [STAGES-1:0][N-1:0] stage_q;
    logic [N-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl = stage_q[STAGES-1];
    assign chg = stage_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/qpc_decode.sv
`timescale 1ns/1ps
module qpc_decode
    import qpc_pkg::*;
(
    input  in_mode_e   mode,
    input  mult_e      mult,
    input  logic       sw_dir,
    input  logic [1:0] lvl,     // [0] = A, [1] = B
    input  logic [1:0] chg,
    output logic       step_up,
    output logic       step_dn
);

    logic a, b, ea, eb, rise_a, rise_b;

    assign a      = lvl[0];
    assign b      = lvl[1];
    assign ea     = chg[0];
    assign eb     = chg[1];
    assign rise_a = ea & a;
    assign rise_b = eb & b;

    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (mode)
            IN_PULSE_BDIR: begin
                step_up = rise_a & ~b;
                step_dn = rise_a &  b;
            end
            IN_PULSE_SWDIR: begin
                step_up = rise_a & ~sw_dir;
                step_dn = rise_a &  sw_dir;
            end
            IN_UPDOWN: begin
                step_up = rise_a & ~rise_b;
                step_dn = rise_b & ~rise_a;
            end
            IN_QUAD: begin
                if (ea && !eb) begin
                    // A edge: forward when new A differs from B
                    if (mult != MUL_X1 || a) begin
                        step_up = (a != b);
                        step_dn = (a == b);
                    end
                end else if (eb && !ea) begin
                    // B edge: forward when new B equals A
                    if (mult == MUL_X4 || mult == MUL_X4B) begin
                        step_up = (a == b);
                        step_dn = (a != b);
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/qpc_core.sv
`timescale 1ns/1ps
module qpc_core
    import qpc_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_up,
    input  logic                 step_dn,
    input  logic                 en,
    input  logic                 ring,
    input  logic signed [CW-1:0] lo,
    input  logic signed [CW-1:0] hi,
    input  logic                 load,
    input  logic signed [CW-1:0] load_val,
    input  logic                 flag_clr,
    output logic signed [CW-1:0] cnt,
    output logic                 carry,
    output logic                 borrow
);

    localparam logic signed [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] MINV = {1'b1, {(CW-1){1'b0}}};

    cnt_state_e           state_q, state_n;
    logic signed [CW-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            CNT_RUN: begin
                if (en && step_up) begin
                    if (ring)              cnt_n = (cnt_q >= hi) ? lo : cnt_q + 1'b1;
                    else if (cnt_q == MAXV) state_n = CNT_CARRY;
                    else                   cnt_n = cnt_q + 1'b1;
                end else if (en && step_dn) begin
                    if (ring)              cnt_n = (cnt_q <= lo) ? hi : cnt_q - 1'b1;
                    else if (cnt_q == MINV) state_n = CNT_BORROW;
                    else                   cnt_n = cnt_q - 1'b1;
                end
            end
            CNT_CARRY, CNT_BORROW: begin
                if (flag_clr) state_n = CNT_RUN;
            end
            default: state_n = CNT_RUN;
        endcase
        if (load) cnt_n = load_val;
    end

    always_comb begin
        cnt    = cnt_q;
        carry  = (state_q == CNT_CARRY);
        borrow = (state_q == CNT_BORROW);
    end

endmodule

// File: rtl/quad_pulse_counter.sv
`timescale 1ns/1ps
module quad_pulse_counter
    import qpc_pkg::*;
#(
    parameter int CW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_a,
    input  logic          pin_b,
    input  logic [1:0]    cfg_in_mode,
    input  logic [1:0]    cfg_mult,
    input  logic          cfg_sw_dir,
    input  logic          cfg_ring,
    input  logic          cnt_en,
    input  logic [CW-1:0] ring_lo,
    input  logic [CW-1:0] ring_hi,
    input  logic [CW-1:0] preset_val,
    input  logic          preset_pin,
    input  logic          preset_sw,
    input  logic          flag_clr,
    output logic [CW-1:0] count,
    output logic          carry_flag,
    output logic          borrow_flag
);

    logic [1:0] ph_lvl, ph_chg;
    logic       step_up, step_dn;

    qpc_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({pin_b, pin_a}),
        .lvl   (ph_lvl),
        .chg   (ph_chg)
    );

    qpc_decode u_dec (
        .mode    (in_mode_e'(cfg_in_mode)),
        .mult    (mult_e'(cfg_mult)),
        .sw_dir  (cfg_sw_dir),
        .lvl     (ph_lvl),
        .chg     (ph_chg),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    qpc_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .en       (cnt_en),
        .ring     (cfg_ring),
        .lo       (ring_lo),
        .hi       (ring_hi),
        .load     (preset_pin | preset_sw),
        .load_val (preset_val),
        .flag_clr (flag_clr),
        .cnt      (count),
        .carry    (carry_flag),
        .borrow   (borrow_flag)
    );

endmodule

// File: rtl/quad_pulse_counter_chk.sv
`timescale 1ns/1ps
module quad_pulse_counter_chk #(
    parameter int CW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_en,
    input logic                 cfg_ring,
    input logic signed [CW-1:0] ring_lo,
    input logic signed [CW-1:0] ring_hi,
    input logic [CW-1:0]        preset_val,
    input logic                 preset_pin,
    input logic                 preset_sw,
    input logic                 flag_clr,
    input logic signed [CW-1:0] count,
    input logic                 carry_flag,
    input logic                 borrow_flag
);

    logic pre_any;
    assign pre_any = preset_pin | preset_sw;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !pre_any) |=> $stable(count));

    // R8
    preset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_any |=> (count == $past(preset_val)));

    // R9
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_flag && !flag_clr) |=> carry_flag);

    // R9
    carry_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_flag && !pre_any) |=> $stable(count));

    // R10
    borrow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (borrow_flag && !flag_clr) |=> borrow_flag);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_flag && borrow_flag));

    // R11
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ring && !pre_any && ring_lo <= ring_hi &&
         count >= ring_lo && count <= ring_hi)
        |=> (count >= $past(ring_lo) && count <= $past(ring_hi)));

endmodule

bind quad_pulse_counter quad_pulse_counter_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .cfg_ring    (cfg_ring),
    .ring_lo     (ring_lo),
    .ring_hi     (ring_hi),
    .preset_val  (preset_val),
    .preset_pin  (preset_pin),
    .preset_sw   (preset_sw),
    .flag_clr    (flag_clr),
    .count       (count),
    .carry_flag  (carry_flag),
    .borrow_flag (borrow_flag)
);

// File: tb/sim_quad_pulse_counter.sv
`timescale 1ns/1ps
module sim_quad_pulse_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic [1:0]  cfg_in_mode = 2'd0, cfg_mult = 2'd0;
    logic        cfg_sw_dir = 1'b0, cfg_ring = 1'b0, cnt_en = 1'b0;
    logic [31:0] ring_lo = '0, ring_hi = '0, preset_val = '0;
    logic        preset_pin = 1'b0, preset_sw = 1'b0, flag_clr = 1'b0;
    logic [31:0] count;
    logic        carry_flag, borrow_flag;

    int checks = 0;
    int errors = 0;
    logic [20:0] ent;

    always #4 clk = ~clk;

    quad_pulse_counter u0 (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .cfg_in_mode(cfg_in_mode), .cfg_mult(cfg_mult), .cfg_sw_dir(cfg_sw_dir),
        .cfg_ring(cfg_ring), .cnt_en(cnt_en), .ring_lo(ring_lo), .ring_hi(ring_hi),
        .preset_val(preset_val), .preset_pin(preset_pin), .preset_sw(preset_sw),
        .flag_clr(flag_clr), .count(count), .carry_flag(carry_flag),
        .borrow_flag(borrow_flag)
    );

    // {mode[2], mult[2], sw_dir, seq of four {a,b}, signed delta[8]}
    localparam logic [20:0] TBL [14] = '{
        {2'd3, 2'd2, 1'b0, 8'b10_11_01_00, 8'h04},  // R2 x4 forward
        {2'd3, 2'd2, 1'b0, 8'b01_11_10_00, 8'hFC},  // R2 x4 reverse
        {2'd3, 2'd1, 1'b0, 8'b10_11_01_00, 8'h02},  // R2 x2 forward
        {2'd3, 2'd0, 1'b0, 8'b10_11_01_00, 8'h01},  // R2 x1 forward
        {2'd3, 2'd0, 1'b0, 8'b01_11_10_00, 8'hFF},  // R2 x1 reverse
        {2'd3, 2'd1, 1'b0, 8'b01_11_10_00, 8'hFE},  // R2 x2 reverse
        {2'd3, 2'd2, 1'b0, 8'b11_00_11_00, 8'h00},  // R3 both phases at once
        {2'd0, 2'd0, 1'b0, 8'b10_00_10_00, 8'h02},  // R4 B low: up
        {2'd0, 2'd0, 1'b0, 8'b11_01_11_01, 8'hFE},  // R4 B high: down
        {2'd1, 2'd0, 1'b0, 8'b10_00_10_00, 8'h02},  // R5 soft up
        {2'd1, 2'd0, 1'b1, 8'b10_00_10_00, 8'hFE},  // R5 soft down
        {2'd2, 2'd0, 1'b0, 8'b10_00_10_00, 8'h02},  // R6 A line up
        {2'd2, 2'd0, 1'b0, 8'b01_00_01_00, 8'hFE},  // R6 B line down
        {2'd2, 2'd0, 1'b0, 8'b11_00_11_00, 8'h00}   // R6 both cancel
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ab_step(input logic [1:0] v);
        @(negedge clk);
        {pin_a, pin_b} = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_a();
        ab_step(2'b10);
        ab_step(2'b00);
    endtask

    task automatic do_preset(input logic [31:0] v, input logic by_pin);
        @(negedge clk);
        preset_val = v;
        if (by_pin) preset_pin = 1'b1; else preset_sw = 1'b1;
        @(negedge clk);
        preset_pin = 1'b0;
        preset_sw  = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 count in reset", count, 32'd0);
        chk("R1 flags in reset", {30'd0, carry_flag, borrow_flag}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 count after reset", count, 32'd0);
        chk("R1 flags after reset", {30'd0, carry_flag, borrow_flag}, 32'd0);

        cnt_en = 1'b1;
        for (int i = 0; i < 14; i++) begin
            ent = TBL[i];
            cfg_in_mode = ent[20:19];
            cfg_mult    = ent[18:17];
            cfg_sw_dir  = ent[16];
            ab_step(2'b00);
            do_preset(32'd0, 1'b0);
            for (int k = 3; k >= 0; k--) ab_step(ent[8 + 2*k +: 2]);
            chk($sformatf("table entry %0d (R2..R6 decode)", i), count, {{24{ent[7]}}, ent[7:0]});
        end

        // R12: latency of three rising edges
        cfg_in_mode = 2'd1; cfg_sw_dir = 1'b0;
        ab_step(2'b00);
        do_preset(32'd0, 1'b0);
        @(negedge clk);
        pin_a = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk("R12 no change after two edges", count, 32'd0);
        @(posedge clk);
        #1 chk("R12 change on third edge", count, 32'd1);
        ab_step(2'b00);

        // R7: enable low blocks counting; R8: preset still lands
        cnt_en = 1'b0;
        pulse_a();
        pulse_a();
        chk("R7 disabled count", count, 32'd1);
        do_preset(32'h0000_1234, 1'b1);
        chk("R8 preset pin while disabled", count, 32'h0000_1234);
        cnt_en = 1'b1;
        do_preset(32'hFFFF_FF00, 1'b0);
        chk("R8 preset sw", count, 32'hFFFF_FF00);

        // R9: carry and hold
        do_preset(32'h7FFF_FFFE, 1'b0);
        pulse_a();
        chk("R9 reach max", count, 32'h7FFF_FFFF);
        chk("R9 no carry yet", {31'd0, carry_flag}, 32'd0);
        pulse_a();
        chk("R9 carry set", {31'd0, carry_flag}, 32'd1);
        chk("R9 held at max", count, 32'h7FFF_FFFF);
        cfg_sw_dir = 1'b1;
        pulse_a();
        chk("R9 held while flagged", count, 32'h7FFF_FFFF);
        chk("R9 carry sticky", {31'd0, carry_flag}, 32'd1);
        clear_flags();
        chk("R9 carry cleared", {31'd0, carry_flag}, 32'd0);
        pulse_a();
        chk("R9 counts after clear", count, 32'h7FFF_FFFE);

        // R10: borrow and hold
        do_preset(32'h8000_0001, 1'b1);
        pulse_a();
        chk("R10 reach min", count, 32'h8000_0000);
        pulse_a();
        pulse_a();
        chk("R10 borrow set", {31'd0, borrow_flag}, 32'd1);
        chk("R10 held at min", count, 32'h8000_0000);
        clear_flags();
        chk("R10 borrow cleared", {31'd0, borrow_flag}, 32'd0);

        // R11: ring wrap both ways
        cfg_ring = 1'b1;
        ring_lo = 32'hFFFF_FFFD;   // -3
        ring_hi = 32'd5;
        cfg_sw_dir = 1'b0;
        do_preset(32'd4, 1'b1);
        pulse_a();
        chk("R11 up to hi", count, 32'd5);
        pulse_a();
        chk("R11 wrap hi to lo", count, 32'hFFFF_FFFD);
        cfg_sw_dir = 1'b1;
        pulse_a();
        chk("R11 wrap lo to hi", count, 32'd5);
        chk("R11 no flags in ring", {30'd0, carry_flag, borrow_flag}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule